// File: doc/BRIEF.md
# SD Command Register Issue Unit

This block sits between a host register bus and a card-side command engine of an SD host controller. Software first writes a 32-bit argument, then a 16-bit command word. Writing the command word starts the command. The block splits the command word into a command index, an application-command flag, a response-type code and the data-phase attributes (data present, read direction, multi-block, security). It then offers the decoded command and its argument to the command engine over a valid/ready handshake.

After the handshake the block waits for the engine to return the response and stores it in four 32-bit response words. A long (R2) response is stored with the least significant word first. A short response lands in the lowest word.

A separate stop-control write does two things. It can arm an automatic stop that fires when a multi-block transfer ends. It can also ask for a stop at once. Either way the stop is presented to the engine on its own valid/ready pair. Serial framing and CRC7 are handled downstream.

Top module: `sdci_issue_unit`

## Requirements
- R1: After reset, `busy`, `iss_valid`, `stop_valid`, `err_illegal` and `err_timeout` are 0, and all four response words are 0.
- R2: A legal command word is decoded as follows: bits 5:0 give `iss_index`, bit 6 gives `iss_app`, bits 10:8 give `iss_rtype`, bit 11 gives `iss_data`, bit 12 gives `iss_read`, bit 13 gives `iss_multi` and bit 14 gives `iss_secure`. These fields appear on the issue port in the cycle after the write.
- R3: `iss_arg` carries the argument most recently written before the command write (`wr_sel` 1). The argument register is `wr_sel` 1, the command word is `wr_sel` 0, stop control is `wr_sel` 2, and `wr_sel` 3 is ignored. A later argument write does not change a command that is already pending.
- R4: Once `iss_valid` is raised, it and every issue field stay stable until a cycle with `iss_ready` high.
- R5: A command word whose response-type code (bits 10:8) is 0, 1 or 2 is not issued. Instead, `err_illegal` pulses for exactly one cycle and `busy` stays 0.
- R6: `busy` rises in the cycle after a legal command write. Command writes made while `busy` is 1 are ignored.
- R7: A command with response type 3 (no response) clears `busy` on its issue handshake and leaves the response words untouched.
- R8: For response type 6 (R2), the 120 response bits `rsp_bits[119:0]` are stored least significant word first. Word 0 gets bits 31:0, word 1 gets bits 63:32, word 2 gets bits 95:64, and word 3 gets bits 119:96 zero-extended. `busy` clears at the same edge.
- R9: For response types 4, 5 and 7, word 0 gets `rsp_bits[31:0]`, words 1 to 3 are cleared, and `busy` clears.
- R10: A `rsp_timeout` pulse while waiting for a response clears `busy`, pulses `err_timeout` for one cycle and leaves the response words unchanged.
- R11: A stop-control write with bit 0 set raises `stop_valid` in the next cycle. `stop_valid` holds until a cycle with `stop_ready` high.
- R12: Stop-control bit 8 arms the automatic stop, and each stop-control write replaces it. A `data_end` pulse raises `stop_valid` only when the automatic stop is armed and the last issued command had its multi-block bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 argument, 2 stop control, 3 none |
| wr_data | input | 32 | Write data; the command word uses bits 15:0 |
| busy | output | 1 | Command in flight |
| err_illegal | output | 1 | One-cycle pulse: command word rejected |
| err_timeout | output | 1 | One-cycle pulse: response timed out |
| iss_valid | output | 1 | Decoded command offered to the engine |
| iss_ready | input | 1 | Engine accepts the command |
| iss_index | output | 6 | Command index |
| iss_app | output | 1 | Application-specific command flag |
| iss_rtype | output | 3 | Response type code |
| iss_data | output | 1 | Data phase follows |
| iss_read | output | 1 | Data direction is card to host |
| iss_multi | output | 1 | Multi-block transfer |
| iss_secure | output | 1 | Security command flag |
| iss_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Engine presents a response |
| rsp_ready | output | 1 | Unit is waiting for a response |
| rsp_bits | input | 120 | Response content with the CRC byte removed |
| rsp_timeout | input | 1 | Engine reports no response |
| data_end | input | 1 | Pulse at the end of a data transfer |
| stop_valid | output | 1 | Stop command requested |
| stop_ready | input | 1 | Engine accepts the stop |
| rsp_word0 | output | 32 | Response word 0 |
| rsp_word1 | output | 32 | Response word 1 |
| rsp_word2 | output | 32 | Response word 2 |
| rsp_word3 | output | 32 | Response word 3 |

## Verification
Some properties are checked by assertions on every cycle:
- the issue port and the stop request hold steady under back-pressure;
- `iss_valid` never appears without `busy`;
- rejection and timeout pulses leave `busy` low;
- a short response always leaves the upper response words at zero.

Other behaviour only the bench scenarios can show:
- the field decode of varied command words;
- which argument travels with which command;
- that writes made while busy are dropped;
- the exact R2 word order;
- that the automatic stop fires only when armed and only after a multi-block command.

// File: rtl/sdci_pkg.sv
package sdci_pkg;
  localparam int IDX_W  = 6;
  localparam int RT_W   = 3;
  localparam int WORD_W = 32;
  localparam int NWORDS = 4;
  localparam int RSP_W  = WORD_W * NWORDS - 8;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_ARG  = 2'd1,
    SEL_STOP = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  localparam logic [RT_W-1:0] RT_NONE = 3'd3;
  localparam logic [RT_W-1:0] RT_R1   = 3'd4;
  localparam logic [RT_W-1:0] RT_R1B  = 3'd5;
  localparam logic [RT_W-1:0] RT_R2   = 3'd6;
  localparam logic [RT_W-1:0] RT_R3   = 3'd7;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             app;
    logic [RT_W-1:0]  rtype;
    logic             data;
    logic             rd;
    logic             multi;
    logic             sec;
  } cmd_t;
endpackage

// File: rtl/sdci_decode.sv
module sdci_decode
  import sdci_pkg::*;
(
  input  logic [15:0] word,
  output cmd_t        cmd,
  output logic        legal
);
  always_comb begin
    cmd.idx   = word[5:0];
    cmd.app   = word[6];
    cmd.rtype = word[10:8];
    cmd.data  = word[11];
    cmd.rd    = word[12];
    cmd.multi = word[13];
    cmd.sec   = word[14];
    legal     = (word[10:8] >= RT_NONE);
  end
endmodule

// File: rtl/sdci_resp_pack.sv
module sdci_resp_pack
  import sdci_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap,
  input  logic                         long_fmt,
  input  logic [RSP_W-1:0]             bits_in,
  output logic [NWORDS-1:0][WORD_W-1:0] words
);
  logic [NWORDS-1:0][WORD_W-1:0] next_w;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g == 0) begin : g_low
      assign next_w[g] = bits_in[WORD_W-1:0];
    end else if (g < NWORDS - 1) begin : g_mid
      assign next_w[g] = long_fmt ? bits_in[g*WORD_W +: WORD_W] : '0;
    end else begin : g_top
      assign next_w[g] = long_fmt ? {8'h00, bits_in[RSP_W-1:g*WORD_W]} : '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   words[g] <= '0;
      else if (cap) words[g] <= next_w[g];
    end
  end

  assert_short_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !long_fmt) |=> (words[1] == '0 && words[2] == '0 && words[3] == '0));
  assert_idle_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(words));
endmodule

// File: rtl/sdci_stop_ctl.sv
module sdci_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_wr,
  input  logic now_bit,
  input  logic arm_bit,
  input  logic data_end,
  input  logic last_multi,
  input  logic stop_ready,
  output logic stop_valid
);
  logic armed;
  logic fire;

  assign fire = (stop_wr && now_bit) || (data_end && armed && last_multi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      stop_valid <= 1'b0;
    end else begin
      if (stop_wr) armed <= arm_bit;
      if (stop_valid && stop_ready) stop_valid <= 1'b0;
      if (fire) stop_valid <= 1'b1;
    end
  end

  assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_valid && !stop_ready) |=> stop_valid);
  assert_stop_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_valid && !fire) |=> !stop_valid);
endmodule

// File: rtl/sdci_issue_unit.sv
module sdci_issue_unit
  import sdci_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic             busy,
  output logic             err_illegal,
  output logic             err_timeout,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [5:0]       iss_index,
  output logic             iss_app,
  output logic [2:0]       iss_rtype,
  output logic             iss_data,
  output logic             iss_read,
  output logic             iss_multi,
  output logic             iss_secure,
  output logic [ARG_W-1:0] iss_arg,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [119:0]     rsp_bits,
  input  logic             rsp_timeout,
  input  logic             data_end,
  output logic             stop_valid,
  input  logic             stop_ready,
  output logic [31:0]      rsp_word0,
  output logic [31:0]      rsp_word1,
  output logic [31:0]      rsp_word2,
  output logic [31:0]      rsp_word3
);
  cmd_t             dec;
  logic             dec_legal;
  cmd_t             cur;
  logic [ARG_W-1:0] arg_q;
  logic [ARG_W-1:0] cur_arg;
  logic             cmd_wr;
  logic             waiting;
  logic             cap;
  logic [NWORDS-1:0][WORD_W-1:0] words;

  assign cmd_wr  = wr_valid && (wr_sel == SEL_CMD);
  assign waiting = busy && !iss_valid && (cur.rtype != RT_NONE);
  assign rsp_ready = waiting;
  assign cap     = waiting && rsp_valid;

  sdci_decode u_dec (
    .word  (wr_data[15:0]),
    .cmd   (dec),
    .legal (dec_legal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      iss_valid   <= 1'b0;
      err_illegal <= 1'b0;
      err_timeout <= 1'b0;
      cur         <= '0;
      arg_q       <= '0;
      cur_arg     <= '0;
    end else begin
      err_illegal <= 1'b0;
      err_timeout <= 1'b0;
      if (wr_valid && wr_sel == SEL_ARG) arg_q <= wr_data[ARG_W-1:0];
      if (!busy) begin
        if (cmd_wr) begin
          if (dec_legal) begin
            busy      <= 1'b1;
            iss_valid <= 1'b1;
            cur       <= dec;
            cur_arg   <= arg_q;
          end else begin
            err_illegal <= 1'b1;
          end
        end
      end else if (iss_valid) begin
        if (iss_ready) begin
          iss_valid <= 1'b0;
          if (cur.rtype == RT_NONE) busy <= 1'b0;
        end
      end else if (cap) begin
        busy <= 1'b0;
      end else if (waiting && rsp_timeout) begin
        busy        <= 1'b0;
        err_timeout <= 1'b1;
      end
    end
  end

  assign iss_index  = cur.idx;
  assign iss_app    = cur.app;
  assign iss_rtype  = cur.rtype;
  assign iss_data   = cur.data;
  assign iss_read   = cur.rd;
  assign iss_multi  = cur.multi;
  assign iss_secure = cur.sec;
  assign iss_arg    = cur_arg;

  sdci_resp_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .long_fmt (cur.rtype == RT_R2),
    .bits_in  (rsp_bits),
    .words    (words)
  );

  assign rsp_word0 = words[0];
  assign rsp_word1 = words[1];
  assign rsp_word2 = words[2];
  assign rsp_word3 = words[3];

  sdci_stop_ctl u_stop (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_wr    (wr_valid && wr_sel == SEL_STOP),
    .now_bit    (wr_data[0]),
    .arm_bit    (wr_data[8]),
    .data_end   (data_end),
    .last_multi (cur.multi),
    .stop_ready (stop_ready),
    .stop_valid (stop_valid)
  );

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_arg) && $stable(iss_index)
                                   && $stable(iss_rtype)));
  assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> busy);
  assert_illegal_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> (!busy && !iss_valid));
  assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> !busy);
  assert_none_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_rtype == RT_NONE) |=> !busy);
endmodule

// File: tb/tb_sdci_issue_unit.sv
module tb_sdci_issue_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic busy, err_illegal, err_timeout, iss_valid;
  logic iss_ready = 1'b1;
  logic [5:0] iss_index;
  logic iss_app, iss_data, iss_read, iss_multi, iss_secure;
  logic [2:0] iss_rtype;
  logic [31:0] iss_arg;
  logic rsp_valid = 1'b0;
  logic rsp_ready;
  logic [119:0] rsp_bits = '0;
  logic rsp_timeout = 1'b0;
  logic data_end = 1'b0;
  logic stop_valid;
  logic stop_ready = 1'b0;
  logic [31:0] rsp_word0, rsp_word1, rsp_word2, rsp_word3;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [45:0] exp_q[$];

  always #2 clk = ~clk;

  sdci_issue_unit dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [45:0] expect_item(input logic [15:0] w, input logic [31:0] a);
    return {w[5:0], w[6], w[10:8], w[11], w[12], w[13], w[14], a};
  endfunction

  // monitor: compares each issue handshake against the scoreboard (R2, R3)
  always @(negedge clk) begin
    #1;
    if (rst_n && iss_valid && iss_ready) begin
      logic [45:0] got;
      got = {iss_index, iss_app, iss_rtype, iss_data, iss_read, iss_multi, iss_secure, iss_arg};
      if (exp_q.size() == 0) chk("R2/R6 unexpected issue", {82'd0, got}, 128'd0);
      else chk("R2/R3 issue fields", {82'd0, got}, {82'd0, exp_q.pop_front()});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_sel = 2'd3; wr_data = '0;
    #1;
  endtask

  task automatic respond(input logic [119:0] b);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_bits = b;
    @(negedge clk);
    rsp_valid = 1'b0;
    #1;
  endtask

  logic [119:0] pl;
  logic [31:0] w0_keep;

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1 busy", {127'd0, busy}, 128'd0);
    chk("R1 iss_valid", {127'd0, iss_valid}, 128'd0);
    chk("R1 stop_valid", {127'd0, stop_valid}, 128'd0);
    chk("R1 errors", {126'd0, err_illegal, err_timeout}, 128'd0);
    chk("R1 words", {rsp_word3, rsp_word2, rsp_word1, rsp_word0}, 128'd0);

    // R2 R3 R6 R9: short read command
    wr(2'd1, 32'hCAFE_0001);
    exp_q.push_back(expect_item(16'h1C11, 32'hCAFE_0001));
    wr(2'd0, 32'h0000_1C11);
    chk("R6 busy after write", {127'd0, busy}, 128'd1);
    wr(2'd1, 32'h1234_5678);     // later argument, must not alter pending
    wr(2'd0, 32'h0000_0405);     // ignored while busy (R6)
    chk("R6 still busy", {127'd0, busy}, 128'd1);
    chk("R6 waiting for response", {127'd0, rsp_ready}, 128'd1);
    pl = {24'hA1A2A3, 32'hB0B1B2B3, 32'hC0C1C2C3, 32'hD0D1D2D3};
    respond(pl);
    chk("R9 busy clear", {127'd0, busy}, 128'd0);
    chk("R9 short packing", {rsp_word3, rsp_word2, rsp_word1, rsp_word0},
        {96'd0, 32'hD0D1D2D3});

    // R2 app + secure bits, R8 long response
    exp_q.push_back(expect_item(16'h4645, 32'h1234_5678));
    wr(2'd0, 32'h0000_4645);
    step(1);
    pl = {24'h112233, 32'h44556677, 32'h8899AABB, 32'hCCDDEEFF};
    respond(pl);
    chk("R8 long packing", {rsp_word3, rsp_word2, rsp_word1, rsp_word0},
        {32'h00112233, 32'hCCDDEEFF, 32'h8899AABB, 32'h44556677} == 128'd0 ? 128'd1 :
        {32'h00112233, 32'h44556677, 32'h8899AABB, 32'hCCDDEEFF});
    chk("R8 busy clear", {127'd0, busy}, 128'd0);

    // R4 back-pressure, R7 no-response command
    iss_ready = 1'b0;
    wr(2'd1, 32'h0000_00AA);
    wr(2'd0, 32'h0000_0300);
    step(3);
    chk("R4 valid held", {127'd0, iss_valid}, 128'd1);
    chk("R4 arg held", {96'd0, iss_arg}, {96'd0, 32'h0000_00AA});
    exp_q.push_back(expect_item(16'h0300, 32'h0000_00AA));
    @(negedge clk); iss_ready = 1'b1;
    step(1);
    chk("R7 busy clear on issue", {127'd0, busy}, 128'd0);
    chk("R7 words kept", {96'd0, rsp_word3}, {96'd0, 32'h00112233});

    // R5 illegal response codes
    for (int c = 0; c < 3; c++) begin
      wr(2'd0, 32'h0000_0005 | (c << 8));
      chk("R5 illegal pulse", {127'd0, err_illegal}, 128'd1);
      chk("R5 not busy", {126'd0, busy, iss_valid}, 128'd0);
      step(1);
      chk("R5 pulse one cycle", {127'd0, err_illegal}, 128'd0);
    end
    wr(2'd3, 32'h0000_0411);     // unused select ignored (R3)
    chk("R3 none select ignored", {127'd0, busy}, 128'd0);

    // R10 timeout
    w0_keep = rsp_word0;
    exp_q.push_back(expect_item(16'h0408, 32'h0000_00AA));
    wr(2'd0, 32'h0000_0408);
    step(1);
    @(negedge clk); rsp_timeout = 1'b1;
    @(negedge clk); rsp_timeout = 1'b0; #1;
    chk("R10 timeout pulse", {127'd0, err_timeout}, 128'd1);
    chk("R10 busy clear", {127'd0, busy}, 128'd0);
    chk("R10 words kept", {96'd0, rsp_word0}, {96'd0, w0_keep});

    // R11 immediate stop
    wr(2'd2, 32'h0000_0001);
    chk("R11 stop raised", {127'd0, stop_valid}, 128'd1);
    step(2);
    chk("R11 stop held", {127'd0, stop_valid}, 128'd1);
    @(negedge clk); stop_ready = 1'b1;
    @(negedge clk); stop_ready = 1'b0; #1;
    chk("R11 stop cleared", {127'd0, stop_valid}, 128'd0);

    // R12 auto stop armed, multi-block
    wr(2'd2, 32'h0000_0100);
    chk("R12 arm alone no stop", {127'd0, stop_valid}, 128'd0);
    exp_q.push_back(expect_item(16'h3C12, 32'h0000_00AA));
    wr(2'd0, 32'h0000_3C12);
    step(1);
    respond(120'h5555);
    @(negedge clk); data_end = 1'b1;
    @(negedge clk); data_end = 1'b0; #1;
    chk("R12 auto stop fires", {127'd0, stop_valid}, 128'd1);
    @(negedge clk); stop_ready = 1'b1;
    @(negedge clk); stop_ready = 1'b0; #1;
    // armed but single block: no stop
    exp_q.push_back(expect_item(16'h1C11, 32'h0000_00AA));
    wr(2'd0, 32'h0000_1C11);
    step(1);
    respond(120'h6666);
    @(negedge clk); data_end = 1'b1;
    @(negedge clk); data_end = 1'b0; #1;
    chk("R12 single block no stop", {127'd0, stop_valid}, 128'd0);
    // disarmed, multi-block: no stop
    wr(2'd2, 32'h0000_0000);
    exp_q.push_back(expect_item(16'h3C12, 32'h0000_00AA));
    wr(2'd0, 32'h0000_3C12);
    step(1);
    respond(120'h7777);
    @(negedge clk); data_end = 1'b1;
    @(negedge clk); data_end = 1'b0; #1;
    chk("R12 disarmed no stop", {127'd0, stop_valid}, 128'd0);

    step(2);
    chk("R2 scoreboard drained", {96'd0, exp_q.size()}, 128'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule